// File: doc/BRIEF.md
# Divider-Phase Aligner for Multi-Device Clock Generation

Each device that uses this block runs a small free-running counter that divides the system clock by four and drives a slow output clock from the counter's top bit. When several devices must present that slow clock with the same phase, one is set as the master and the others as followers. The master emits a one-cycle pulse once per counter period. Each follower receives that pulse after a board delay the user programs. It passes the pulse through a synchronizer and finds its leading edge. At that moment it checks its own counter against the value the master's counter must hold. On a mismatch it freezes its counter for one system clock. This repeats on every pulse, so a follower that is off by k states locks after k mismatching pulses. It also relocks by itself after any disturbance.

Two manual modes let the phase be moved by hand in single system-clock steps. In the hardware-driven mode, every leading edge on the sync input freezes the counter once, with no comparison. In the register-driven mode, a one-cycle write strobe freezes it once. The request is consumed as it acts, so it clears itself.

Top module: `divstate_sync`

## Requirements
- R1: While rst_n is low, sync_clk and sync_out are 0 and the divider state is 0.
- R2: With no freeze, the divider steps 0,1,2,3,0 on every clock. sync_clk is 1 in states 2 and 3, so it runs at a quarter of the clock rate with 50% duty.
- R3: With is_master=1, sync_out is high for exactly one cycle, in the cycle after the divider leaves state 0. A follower (is_master=0) keeps sync_out at 0.
- R4: sync_in passes through two synchronizing flops before edge detection. A level held high counts as one leading edge only.
- R5: Mode encoding is 00 idle, 01 automatic, 10 hardware manual, 11 register manual. In automatic mode, a follower compares its divider state with (dly_sel+1+2) mod 4 in the cycle its leading edge is detected. dly_sel+1 is the delay of 1 to 16 cycles after the master's state 0. On a mismatch the divider holds for exactly one cycle; on a match it advances.
- R6: In automatic mode the comparison repeats on every pulse. A follower fed one pulse per 4 cycles locks, whatever its starting phase or a later disturbance, and then keeps the divider at (dly_sel+3) mod 4 in each detection cycle.
- R7: A master in automatic mode never freezes its divider, whatever arrives on sync_in.
- R8: In hardware manual mode, each detected leading edge freezes the divider for one cycle, whatever the role and the divider state.
- R9: In register manual mode, each cycle with sw_stall_wr=1 freezes the divider in the following cycle, once. Writes in consecutive cycles freeze it in consecutive cycles.
- R10: In idle mode, and for sw_stall_wr outside register manual mode, nothing freezes the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 = master role, 0 = follower |
| mode | input | 2 | 00 idle, 01 automatic, 10 hardware manual, 11 register manual |
| dly_sel | input | 4 | Programmed pulse delay minus one (0..15 means 1..16 cycles) |
| sw_stall_wr | input | 1 | One-cycle write strobe requesting one freeze |
| sync_in | input | 1 | Pulse from the master, asynchronous |
| sync_out | output | 1 | Master's once-per-period pulse |
| sync_clk | output | 1 | Divided clock, system clock / 4 |

## Verification
In register manual mode, a new write strobe can land in the same cycle as the freeze that the previous write requested. The bench drives sw_stall_wr high on two and then three adjacent cycles and expects the freezes back to back, with no write lost or merged. A cycle-accurate reference model in the bench judges sync_clk on every clock. In automatic mode, a leading edge can also be detected in a cycle where the divider already matches. The bench starts the follower at every phase offset and checks that no freeze happens once it is locked.

// File: rtl/divsync_pkg.sv
package divsync_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_AUTO = 2'b01,
        MODE_HW   = 2'b10,
        MODE_SW   = 2'b11
    } ds_mode_e;

endpackage

// File: rtl/ds_input_sync.sv
module ds_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], sync_in};
        st_d.prev = st_q.sh[STAGES-1];
        rise      = st_q.sh[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a detected edge lasts a single cycle
    assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ds_divider.sv
module ds_divider #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             is_master,
    output logic [DIV_W-1:0] cnt,
    output logic             sync_clk,
    output logic             sync_out
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             pulse;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cnt   = stall ? st_q.cnt : st_q.cnt + 1'b1;
        st_d.pulse = is_master & (st_q.cnt == '0) & ~stall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign sync_clk = st_q.cnt[DIV_W-1];
    assign sync_out = st_q.pulse;

    // R3: the pulse is one cycle wide
    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !sync_out);
endmodule

// File: rtl/ds_stall_ctrl.sv
module ds_stall_ctrl
    import divsync_pkg::*;
#(
    parameter int DIV_W  = 2,
    parameter int DLY_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ds_mode_e         mode,
    input  logic             is_master,
    input  logic             rise,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic             sw_wr,
    input  logic [DIV_W-1:0] cnt,
    output logic             stall
);
    localparam int SUM_W = DLY_W + DIV_W + 2;

    typedef struct packed {
        logic req;
    } st_t;

    st_t              st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic [DIV_W-1:0] expect_st;
    logic             stall_auto, stall_hw, stall_sw;

    always_comb begin
        sum        = SUM_W'(dly_sel) + SUM_W'(STAGES + 1);
        expect_st  = sum[DIV_W-1:0];
        stall_auto = (mode == MODE_AUTO) & ~is_master & rise & (cnt != expect_st);
        stall_hw   = (mode == MODE_HW) & rise;
        stall_sw   = (mode == MODE_SW) & st_q.req;
        stall      = stall_auto | stall_hw | stall_sw;
        st_d       = st_q;
        st_d.req   = (mode == MODE_SW) & sw_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a register-mode freeze always follows a write
    assert_sw_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && mode == MODE_SW) |-> $past(sw_wr && mode == MODE_SW));
    // R10: idle never freezes
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE) |-> !stall);
endmodule

// File: rtl/divstate_sync.sv
module divstate_sync
    import divsync_pkg::*;
#(
    parameter int DIV_W       = 2,
    parameter int DLY_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic [1:0]       mode,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic             sw_stall_wr,
    input  logic             sync_in,
    output logic             sync_out,
    output logic             sync_clk
);
    ds_mode_e         mode_e;
    logic             rise;
    logic             stall;
    logic [DIV_W-1:0] cnt;

    assign mode_e = ds_mode_e'(mode);

    ds_input_sync #(.STAGES(SYNC_STAGES)) u_insync (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .rise(rise)
    );

    ds_stall_ctrl #(.DIV_W(DIV_W), .DLY_W(DLY_W), .STAGES(SYNC_STAGES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode_e), .is_master(is_master),
        .rise(rise), .dly_sel(dly_sel), .sw_wr(sw_stall_wr), .cnt(cnt),
        .stall(stall)
    );

    ds_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .stall(stall), .is_master(is_master),
        .cnt(cnt), .sync_clk(sync_clk), .sync_out(sync_out)
    );

    // R3: the master pulse sits in the low half of the divided clock
    assert_pulse_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> !sync_clk);
    // R7: an automatic master ignores its sync input
    assert_master_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && mode_e == MODE_AUTO) |-> !stall);
endmodule

// File: tb/divstate_sync_bench.sv
module divstate_sync_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [3:0] dly_sel = 4'd0;
    logic       sw_stall_wr = 1'b0;
    logic       sync_in = 1'b0;
    logic       sync_out, sync_clk;

    int    vectors = 0;
    int    errors  = 0;
    string tag = "R1";

    // reference model state
    int m_cnt = 0, m_out = 0, m_s1 = 0, m_s2 = 0, m_prev = 0, m_req = 0;

    always #10 clk = ~clk;

    divstate_sync u_divstate_sync (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .mode(mode),
        .dly_sel(dly_sel), .sw_stall_wr(sw_stall_wr), .sync_in(sync_in),
        .sync_out(sync_out), .sync_clk(sync_clk)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_out = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_req = 0;
        end else begin
            int  expv;
            bit  edge_seen, frz;
            edge_seen = (m_s2 == 1) && (m_prev == 0);
            expv = (int'(dly_sel) + 3) % 4;
            frz = 0;
            case (mode)
                2'b01: frz = !is_master && edge_seen && (m_cnt != expv);
                2'b10: frz = edge_seen;
                2'b11: frz = (m_req == 1);
                default: frz = 0;
            endcase
            m_out  = (is_master && m_cnt == 0 && !frz) ? 1 : 0;
            m_req  = (mode == 2'b11 && sw_stall_wr) ? 1 : 0;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = int'(sync_in);
            if (!frz) m_cnt = (m_cnt + 1) % 4;
        end
    end

    task automatic chk(input string what, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        chk("sync_clk vs model", int'(sync_clk), (m_cnt >= 2) ? 1 : 0);
        chk("sync_out vs model", int'(sync_out), m_out);
    end

    task automatic count_cycles(input int n, output int clk_hi, output int out_hi);
        clk_hi = 0; out_hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clk_hi += int'(sync_clk);
            out_hi += int'(sync_out);
        end
    endtask

    // follower lock run: pulse every 4 cycles at phase ph
    task automatic lock_run(input int dly, input int ph);
        int ex;
        dly_sel = 4'(dly);
        ex = (dly + 3) % 4;
        for (int j = 0; j < 48; j++) begin
            @(negedge clk);
            if (j >= 32 && (j % 4) == ((ph + 2) % 4))
                chk("locked state level R6", int'(sync_clk), (ex >= 2) ? 1 : 0);
            if (j >= 32 && (j % 4) == ((ph + 3) % 4))
                chk("locked next level R5", int'(sync_clk), (((ex + 1) % 4) >= 2) ? 1 : 0);
            sync_in = ((j % 4) == ph);
        end
        sync_in = 1'b0;
    endtask

    initial begin
        int ch, oh;
        fork
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
            begin
                tag = "R1";
                repeat (3) @(negedge clk);
                chk("sync_clk in reset R1", int'(sync_clk), 0);
                chk("sync_out in reset R1", int'(sync_out), 0);
                rst_n = 1'b1;

                tag = "R2";
                count_cycles(16, ch, oh);
                chk("sync_clk highs in 16 R2", ch, 8);
                chk("follower sync_out highs R3", oh, 0);

                tag = "R3";
                @(negedge clk); is_master = 1'b1;
                count_cycles(4, ch, oh);
                count_cycles(16, ch, oh);
                chk("master pulses in 16 R3", oh, 4);

                tag = "R10";
                is_master = 1'b0;
                for (int i = 0; i < 16; i++) begin
                    @(negedge clk);
                    sw_stall_wr = (i % 2 == 0);
                    sync_in     = (i % 3 == 0);
                end
                @(negedge clk); sw_stall_wr = 1'b0; sync_in = 1'b0;
                mode = 2'b01;
                for (int i = 0; i < 8; i++) begin
                    @(negedge clk); sw_stall_wr = 1'b1;
                end
                @(negedge clk); sw_stall_wr = 1'b0; mode = 2'b00;
                count_cycles(16, ch, oh);
                chk("idle sync_clk highs R10", ch, 8);

                tag = "R5";
                mode = 2'b01;
                for (int ph = 0; ph < 4; ph++) lock_run(0, ph);
                tag = "R6";
                lock_run(2, 1);
                lock_run(13, 3);
                lock_run(15, 0);
                lock_run(6, 2);

                tag = "R7";
                is_master = 1'b1;
                for (int j = 0; j < 24; j++) begin
                    @(negedge clk); sync_in = (j % 3 == 0);
                end
                sync_in = 1'b0;
                count_cycles(16, ch, oh);
                chk("auto master pulses R7", oh, 4);

                tag = "R8";
                mode = 2'b10;
                @(negedge clk); sync_in = 1'b1;
                count_cycles(6, ch, oh);
                count_cycles(12, ch, oh);
                chk("held level freezes once R4", ch, 6);
                @(negedge clk); sync_in = 1'b0;
                is_master = 1'b0;
                for (int j = 0; j < 20; j++) begin
                    @(negedge clk); sync_in = (j % 5 == 0);
                end
                sync_in = 1'b0;
                count_cycles(8, ch, oh);

                tag = "R9";
                mode = 2'b11;
                @(negedge clk); sw_stall_wr = 1'b1;
                @(negedge clk); sw_stall_wr = 1'b0;
                count_cycles(6, ch, oh);
                @(negedge clk); sw_stall_wr = 1'b1;
                @(negedge clk);
                @(negedge clk); sw_stall_wr = 1'b0;
                count_cycles(6, ch, oh);
                @(negedge clk); sw_stall_wr = 1'b1;
                repeat (2) @(negedge clk);
                @(negedge clk); sw_stall_wr = 1'b0;
                count_cycles(4, ch, oh);
                count_cycles(8, ch, oh);
                chk("steady after writes R9", ch, 4);
                mode = 2'b00;
                count_cycles(4, ch, oh);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule